// File: doc/BRIEF.md
# Linked-Chain Serial Result Formatter

This block turns a frame of parallel receiver results into a three-wire serial stream: a bit clock, a data line and a frame sync. There are seven result word types: in-phase, quadrature, magnitude, phase, frequency, gain level and timing error. Each word type owns a small link field that names the type to send after it. The transmit order is therefore a chain that software sets up one hop at a time, not a fixed list.

A single start pulse launches a frame at a programmable entry type. The block follows the chain until it reaches the terminator code. It also stops after seven words, so a chain that loops back on itself still ends. The bit rate is the processing clock divided by 16, 8, 4 or 2, or the processing clock itself. Configuration bits set the clock phase against the data, the sync polarity, and whether sync leads or trails each word. The in-phase word can carry a forced least significant bit as a tag.

Type codes: 000 in-phase, 001 quadrature, 010 magnitude, 011 phase, 100 frequency, 101 gain level, 110 timing error, 111 terminator.

Top module: `lcs_serial_tx`

## Requirements
- R1: A start pulse is accepted only while `busy` is low and the registered entry code is not 111. The first bit slot begins at the clock edge that samples `start`, and `busy` rises at that edge. Any other start pulse is ignored and leaves the outputs untouched.
- R2: The link field for type t is `link_cfg[3t+2:3t]`. After a word of type t the block sends the type named by that field. The frame ends after a word whose field is 111, or after the seventh word, whichever comes first.
- R3: The word of type t is `words[16t+15:16t]`. It is sent MSB first over 16 consecutive bit slots. Its value is taken at the clock edge where its first bit slot begins.
- R4: Every bit slot lasts a number of processing clock cycles set by `div_code`: 000 gives 16, 001 gives 8, 010 gives 4, 011 gives 2, and 1xx gives 1.
- R5: `sclk` rests at level `~clk_normal` while idle and during the first half of each slot. It takes the opposite level in the second half. With `clk_normal`=1, data changes coincide with a falling edge; with 0, they coincide with a rising edge. At full rate, `sclk` is the gated processing clock with that same phase.
- R6: With `sync_inv`=0 the sync is active high; with 1 it is active low. Outside its active slots `ssync` holds the deasserted level.
- R7: With `sync_early`=1, sync is active for exactly the one slot before each word's first bit. For the first word this is an extra leading slot with `sdata` low. For the other words it is the previous word's last bit.
- R8: With `sync_early`=0, sync is active for exactly the one slot after each word's last bit. This is the next word's first bit, or, after the final word, an extra trailing slot with `sdata` low.
- R9: `tag_ctl` acts on in-phase words only. 00 keeps the LSB, 01 sends it as 0, and 1x sends it as 1.
- R10: `busy` stays high from the accepting edge to the end of the last slot, including any leading or trailing sync slot. `sdata` is low whenever no data bit is being sent.
- R11: All configuration inputs pass through a register stage. A change made while idle shows on the outputs two clock edges later, not one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame launch pulse |
| first_code | input | 3 | Entry type code of the chain |
| link_cfg | input | 21 | Seven 3-bit next-type fields, type t at bits 3t+2:3t |
| div_code | input | 3 | Bit rate selector |
| sync_inv | input | 1 | 1 makes sync active low |
| clk_normal | input | 1 | 1: falling edge at data change; 0: rising edge at data change |
| sync_early | input | 1 | 1: sync leads each word; 0: sync trails each word |
| tag_ctl | input | 2 | LSB handling for in-phase words |
| words | input | 112 | Seven 16-bit result words, type t at bits 16t+15:16t |
| sclk | output | 1 | Serial bit clock |
| sdata | output | 1 | Serial data, MSB first |
| ssync | output | 1 | Word sync |
| busy | output | 1 | Frame in progress |

## Verification
The assertions check these rules on every cycle:
- a frame starts only after a valid start;
- the word count stays within the cap;
- `sdata` holds still inside a slot and stays low in the leading and trailing slots;
- a sync pulse lasts one slot;
- `sclk` returns to its resting level only at a slot boundary.

Only the bench scenarios can show the rest, by comparing the whole serial stream against a model of the chain:
- that the words come out in chain order with the right values;
- that a word's value is captured at its own start;
- that sync sits in the correct slot for each placement;
- that the tag bit and the per-code divider ratios are right;
- that stray start pulses and the terminator entry code are ignored;
- the two-edge configuration latency.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_LEAD = 2'd1,
    SLOT_DATA = 2'd2,
    SLOT_TAIL = 2'd3
  } slot_kind_e;

  typedef struct packed {
    logic [2:0] div_code;
    logic       sync_inv;
    logic       clk_normal;
    logic       sync_early;
    logic [1:0] tag_ctl;
  } fmt_cfg_t;

  // log2 of the slot length in processing clock cycles
  function automatic logic [2:0] slot_log2(input logic [2:0] code);
    logic [2:0] r;
    case (code)
      3'b000:  r = 3'd4;
      3'b001:  r = 3'd3;
      3'b010:  r = 3'd2;
      3'b011:  r = 3'd1;
      default: r = 3'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lcs_cfg_reg.sv
module lcs_cfg_reg
  import lcs_pkg::*;
#(
  parameter int LINK_W    = 3,
  parameter int NUM_TYPES = 7
) (
  input  logic                          clk,
  input  logic                          rst,
  input  fmt_cfg_t                      fmt_in,
  input  logic [NUM_TYPES*LINK_W-1:0]   link_in,
  input  logic [LINK_W-1:0]             first_in,
  output fmt_cfg_t                      fmt_q,
  output logic [NUM_TYPES*LINK_W-1:0]   link_q,
  output logic [LINK_W-1:0]             first_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q   <= '0;
      link_q  <= '1;
      first_q <= '1;
    end else begin
      fmt_q   <= fmt_in;
      link_q  <= link_in;
      first_q <= first_in;
    end
  end

endmodule

// File: rtl/lcs_bit_timer.sv
module lcs_bit_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy_d,
  input  logic             busy_q,
  input  logic [2:0]       rlog2,
  output logic             slot_end,
  output logic [CNT_W-1:0] cnt_d,
  output logic [CNT_W-1:0] cnt_q
);

  localparam int LIM_W = CNT_W + 1;

  logic [LIM_W-1:0] last_cnt;

  assign last_cnt = (LIM_W'(1) << rlog2) - LIM_W'(1);
  assign slot_end = busy_q && ({1'b0, cnt_q} == last_cnt);

  always_comb begin
    if (!busy_d || !busy_q || slot_end) cnt_d = '0;
    else                                 cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

endmodule

// File: rtl/lcs_sclk_gen.sv
module lcs_sclk_gen #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy_d,
  input  logic             busy_q,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [2:0]       rlog2,
  input  logic             clk_normal,
  output logic             sclk
);

  localparam int LIM_W = CNT_W + 1;

  logic [LIM_W-1:0] half;
  logic             rest_lvl;
  logic             full_rate;
  logic             sclk_q;

  assign half      = (LIM_W'(1) << rlog2) >> 1;
  assign rest_lvl  = ~clk_normal;
  assign full_rate = (rlog2 == 3'd0);

  always_ff @(posedge clk) begin
    if (rst)
      sclk_q <= 1'b1;
    else if (busy_d && !full_rate)
      sclk_q <= ({1'b0, cnt_d} < half) ? rest_lvl : ~rest_lvl;
    else
      sclk_q <= rest_lvl;
  end

  // full rate: gated processing clock, first half of each cycle at rest level
  assign sclk = (full_rate && busy_q) ? (clk_normal ? ~clk : clk) : sclk_q;

  // R5: the clock only returns to its resting level at a slot boundary
  p_sclk_rest_at_boundary_r5: assert property (@(posedge clk) disable iff (rst)
    (rlog2 != 3'd0) && busy_q && $past(busy_q) && $stable(rlog2) &&
    $stable(clk_normal) && !$stable(sclk_q) && (sclk_q == rest_lvl)
    |-> (cnt_q == '0));

endmodule

// File: rtl/lcs_word_select.sv
module lcs_word_select #(
  parameter int WORD_W    = 16,
  parameter int NUM_TYPES = 7,
  parameter int LINK_W    = 3
) (
  input  logic [NUM_TYPES*WORD_W-1:0] words,
  input  logic [LINK_W-1:0]           code,
  input  logic [1:0]                  tag_ctl,
  output logic [WORD_W-1:0]           word
);

  logic [WORD_W-1:0] slot_word [NUM_TYPES];

  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_slice
    assign slot_word[t] = words[t*WORD_W +: WORD_W];
  end

  always_comb begin
    word = '0;
    for (int t = 0; t < NUM_TYPES; t++) begin
      if (code == LINK_W'(t)) word = slot_word[t];
    end
    // in-phase words (code 0) may carry a forced LSB
    if (code == '0) begin
      if (tag_ctl[1])      word[0] = 1'b1;
      else if (tag_ctl[0]) word[0] = 1'b0;
    end
  end

endmodule

// File: rtl/lcs_frame_seq.sv
module lcs_frame_seq
  import lcs_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int NUM_TYPES = 7,
  parameter int LINK_W    = 3,
  parameter int MAX_WORDS = 7
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        slot_end,
  input  logic                        sync_early,
  input  logic                        sync_inv,
  input  logic [LINK_W-1:0]           first_code,
  input  logic [NUM_TYPES*LINK_W-1:0] link_cfg,
  input  logic [WORD_W-1:0]           load_word,
  output logic [LINK_W-1:0]           load_code,
  output logic                        busy_d,
  output logic                        busy_q,
  output logic                        sdata,
  output logic                        ssync
);

  localparam int                BIT_W    = $clog2(WORD_W);
  localparam int                WC_W     = $clog2(MAX_WORDS + 1);
  localparam logic [LINK_W-1:0] END_CODE = '1;

  slot_kind_e        kind_q, kind_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [LINK_W-1:0] code_q, code_d;
  logic [WC_W-1:0]   wcnt_q, wcnt_d;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic              sdata_q, sdata_d;
  logic              act_q, act_d;
  logic              ssync_q;
  logic [LINK_W-1:0] link_next;
  logic              has_more;
  logic              start_ok;
  logic              last_bit;
  logic              prelast_bit;

  assign link_next   = link_cfg[code_q*LINK_W +: LINK_W];
  assign has_more    = (link_next != END_CODE) && (wcnt_q < WC_W'(MAX_WORDS));
  assign start_ok    = start && (kind_q == SLOT_IDLE) && (first_code != END_CODE);
  assign last_bit    = (bit_q == BIT_W'(WORD_W - 1));
  assign prelast_bit = (bit_q == BIT_W'(WORD_W - 2));

  always_comb begin
    case (kind_q)
      SLOT_IDLE: load_code = first_code;
      SLOT_LEAD: load_code = code_q;
      default:   load_code = link_next;
    endcase
  end

  always_comb begin
    kind_d  = kind_q;
    bit_d   = bit_q;
    code_d  = code_q;
    wcnt_d  = wcnt_q;
    shreg_d = shreg_q;
    sdata_d = sdata_q;
    act_d   = act_q;
    busy_d  = busy_q;
    case (kind_q)
      SLOT_IDLE: begin
        act_d   = 1'b0;
        sdata_d = 1'b0;
        busy_d  = 1'b0;
        if (start_ok) begin
          busy_d = 1'b1;
          code_d = first_code;
          wcnt_d = WC_W'(1);
          if (sync_early) begin
            kind_d = SLOT_LEAD;
            act_d  = 1'b1;
          end else begin
            kind_d  = SLOT_DATA;
            bit_d   = '0;
            sdata_d = load_word[WORD_W-1];
            shreg_d = load_word << 1;
          end
        end
      end
      SLOT_LEAD: begin
        if (slot_end) begin
          kind_d  = SLOT_DATA;
          bit_d   = '0;
          sdata_d = load_word[WORD_W-1];
          shreg_d = load_word << 1;
          act_d   = 1'b0;
        end
      end
      SLOT_DATA: begin
        if (slot_end) begin
          if (!last_bit) begin
            bit_d   = bit_q + BIT_W'(1);
            sdata_d = shreg_q[WORD_W-1];
            shreg_d = shreg_q << 1;
            act_d   = sync_early && prelast_bit && has_more;
          end else if (has_more) begin
            code_d  = link_next;
            wcnt_d  = wcnt_q + WC_W'(1);
            bit_d   = '0;
            sdata_d = load_word[WORD_W-1];
            shreg_d = load_word << 1;
            act_d   = !sync_early;
          end else if (!sync_early) begin
            kind_d  = SLOT_TAIL;
            sdata_d = 1'b0;
            act_d   = 1'b1;
          end else begin
            kind_d  = SLOT_IDLE;
            sdata_d = 1'b0;
            act_d   = 1'b0;
            busy_d  = 1'b0;
          end
        end
      end
      default: begin
        if (slot_end) begin
          kind_d  = SLOT_IDLE;
          sdata_d = 1'b0;
          act_d   = 1'b0;
          busy_d  = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q  <= SLOT_IDLE;
      bit_q   <= '0;
      code_q  <= '0;
      wcnt_q  <= '0;
      shreg_q <= '0;
      sdata_q <= 1'b0;
      act_q   <= 1'b0;
      ssync_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      kind_q  <= kind_d;
      bit_q   <= bit_d;
      code_q  <= code_d;
      wcnt_q  <= wcnt_d;
      shreg_q <= shreg_d;
      sdata_q <= sdata_d;
      act_q   <= act_d;
      ssync_q <= act_d ^ sync_inv;
      busy_q  <= busy_d;
    end
  end

  assign sdata = sdata_q;
  assign ssync = ssync_q;

  // R1: a frame begins only after an accepted start
  p_start_accept_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> ($past(start) && ($past(first_code) != END_CODE)));

  // R2: the word count never passes the cap
  p_word_cap_r2: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> ((wcnt_q >= WC_W'(1)) && (wcnt_q <= WC_W'(MAX_WORDS))));

  // R3: the data line only moves at slot boundaries
  p_data_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q) && !$past(slot_end)) |-> $stable(sdata_q));

  // R7, R8: a sync pulse lasts exactly one slot
  p_sync_one_slot_r7: assert property (@(posedge clk) disable iff (rst)
    (act_q && slot_end) |=> !act_q);

  // R8: the trailing slot carries sync with the data line low
  p_tail_sync_r8: assert property (@(posedge clk) disable iff (rst)
    (kind_q == SLOT_TAIL) |-> (act_q && !sdata_q));

  // R10: data line low whenever no data bit is on it
  p_gap_low_r10: assert property (@(posedge clk) disable iff (rst)
    (kind_q != SLOT_DATA) |-> !sdata_q);

endmodule

// File: rtl/lcs_serial_tx.sv
module lcs_serial_tx
  import lcs_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int NUM_TYPES = 7,
  parameter int LINK_W    = 3,
  parameter int MAX_WORDS = 7,
  parameter int CNT_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [LINK_W-1:0]           first_code,
  input  logic [NUM_TYPES*LINK_W-1:0] link_cfg,
  input  logic [2:0]                  div_code,
  input  logic                        sync_inv,
  input  logic                        clk_normal,
  input  logic                        sync_early,
  input  logic [1:0]                  tag_ctl,
  input  logic [NUM_TYPES*WORD_W-1:0] words,
  output logic                        sclk,
  output logic                        sdata,
  output logic                        ssync,
  output logic                        busy
);

  fmt_cfg_t                      fmt_in, fmt_q;
  logic [NUM_TYPES*LINK_W-1:0]   link_q;
  logic [LINK_W-1:0]             first_q;
  logic [LINK_W-1:0]             load_code;
  logic [WORD_W-1:0]             load_word;
  logic                          busy_d, busy_q;
  logic                          slot_end;
  logic [CNT_W-1:0]              cnt_d, cnt_q;
  logic [2:0]                    rlog2;

  assign fmt_in = '{div_code:   div_code,
                    sync_inv:   sync_inv,
                    clk_normal: clk_normal,
                    sync_early: sync_early,
                    tag_ctl:    tag_ctl};

  assign rlog2 = slot_log2(fmt_q.div_code);

  lcs_cfg_reg #(.LINK_W(LINK_W), .NUM_TYPES(NUM_TYPES)) u_cfg (
    .clk(clk), .rst(rst), .fmt_in(fmt_in), .link_in(link_cfg), .first_in(first_code),
    .fmt_q(fmt_q), .link_q(link_q), .first_q(first_q)
  );

  lcs_word_select #(.WORD_W(WORD_W), .NUM_TYPES(NUM_TYPES), .LINK_W(LINK_W)) u_sel (
    .words(words), .code(load_code), .tag_ctl(fmt_q.tag_ctl), .word(load_word)
  );

  lcs_frame_seq #(.WORD_W(WORD_W), .NUM_TYPES(NUM_TYPES), .LINK_W(LINK_W),
                  .MAX_WORDS(MAX_WORDS)) u_seq (
    .clk(clk), .rst(rst), .start(start), .slot_end(slot_end),
    .sync_early(fmt_q.sync_early), .sync_inv(fmt_q.sync_inv),
    .first_code(first_q), .link_cfg(link_q), .load_word(load_word),
    .load_code(load_code), .busy_d(busy_d), .busy_q(busy_q),
    .sdata(sdata), .ssync(ssync)
  );

  lcs_bit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .busy_d(busy_d), .busy_q(busy_q), .rlog2(rlog2),
    .slot_end(slot_end), .cnt_d(cnt_d), .cnt_q(cnt_q)
  );

  lcs_sclk_gen #(.CNT_W(CNT_W)) u_sclk (
    .clk(clk), .rst(rst), .busy_d(busy_d), .busy_q(busy_q), .cnt_d(cnt_d),
    .cnt_q(cnt_q), .rlog2(rlog2), .clk_normal(fmt_q.clk_normal), .sclk(sclk)
  );

  assign busy = busy_q;

endmodule

// File: tb/lcs_serial_tx_tb.sv
module lcs_serial_tx_tb_top;

  localparam int W  = 16;
  localparam int NT = 7;
  localparam int LW = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [LW-1:0]   first_code = 3'd0;
  logic [NT*LW-1:0] link_cfg = '1;
  logic [2:0]      div_code = 3'd3;
  logic            sync_inv = 1'b0;
  logic            clk_normal = 1'b1;
  logic            sync_early = 1'b0;
  logic [1:0]      tag_ctl = 2'b00;
  logic [NT*W-1:0] words = '0;
  logic [NT*W-1:0] w_new = '0;
  logic            sclk, sdata, ssync, busy;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic exp_d [0:127];
  logic exp_s [0:127];
  int   n_slots;

  always #4 clk = ~clk;

  lcs_serial_tx dut_i (
    .clk(clk), .rst(rst), .start(start), .first_code(first_code), .link_cfg(link_cfg),
    .div_code(div_code), .sync_inv(sync_inv), .clk_normal(clk_normal),
    .sync_early(sync_early), .tag_ctl(tag_ctl), .words(words),
    .sclk(sclk), .sdata(sdata), .ssync(ssync), .busy(busy)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] word_of(input logic [NT*W-1:0] ws, input int t,
                                           input logic [1:0] tg);
    logic [W-1:0] v;
    v = ws[t*W +: W];
    if (t == 0) begin
      if (tg[1])      v[0] = 1'b1;
      else if (tg[0]) v[0] = 1'b0;
    end
    return v;
  endfunction

  task automatic build_model(input bit chg);
    int seq [0:6];
    int n;
    int c;
    logic [W-1:0] v;
    n = 0;
    c = int'(first_code);
    while (c != 7 && n < 7) begin
      seq[n] = c;
      n++;
      c = int'(link_cfg[c*LW +: LW]);
    end
    n_slots = 0;
    if (sync_early) begin
      exp_d[0] = 1'b0; exp_s[0] = 1'b1; n_slots = 1;
    end
    for (int w = 0; w < n; w++) begin
      v = word_of((chg && w > 0) ? w_new : words, seq[w], tag_ctl);
      for (int b = W - 1; b >= 0; b--) begin
        exp_d[n_slots] = v[b];
        exp_s[n_slots] = sync_early ? (b == 0 && w < n - 1) : (b == W - 1 && w > 0);
        n_slots++;
      end
    end
    if (!sync_early) begin
      exp_d[n_slots] = 1'b0; exp_s[n_slots] = 1'b1; n_slots++;
    end
  endtask

  task automatic run_frame(input bit chg, input bit poke);
    int  nn, total, s, c;
    bit  bd, bs, bc, bb;
    int  ad, ed, as_, es, ac, ec, ab;
    logic xs, xc;
    bd = 0; bs = 0; bc = 0; bb = 0;
    ad = 0; ed = 0; as_ = 0; es = 0; ac = 0; ec = 0; ab = 0;
    repeat (3) @(negedge clk);
    nn = div_code[2] ? 1 : (16 >> div_code[1:0]);
    build_model(chg);
    total = n_slots * nn;
    start = 1'b1;
    for (int j = 0; j <= total; j++) begin
      @(negedge clk);
      if (j == 0) start = 1'b0;
      if (j < total) begin
        s  = j / nn;
        c  = j % nn;
        xs = exp_s[s] ^ sync_inv;
        xc = (nn == 1) ? clk_normal : ((c < nn / 2) ? ~clk_normal : clk_normal);
        if (sdata !== exp_d[s] && !bd) begin bd = 1; ad = int'(sdata); ed = int'(exp_d[s]); end
        if (ssync !== xs && !bs) begin bs = 1; as_ = int'(ssync); es = int'(xs); end
        if (sclk !== xc && !bc) begin bc = 1; ac = int'(sclk); ec = int'(xc); end
        if (busy !== 1'b1 && !bb) begin bb = 1; ab = int'(busy); end
      end else begin
        check(busy === 1'b0 && sdata === 1'b0 && ssync === sync_inv && sclk === ~clk_normal,
              "R10 idle levels after frame {busy,sdata,ssync,sclk}",
              int'({busy, sdata, ssync, sclk}), int'({1'b0, 1'b0, sync_inv, ~clk_normal}));
      end
      if (chg && j == nn) words = w_new;
      if (poke && j == 3) start = 1'b1;
      if (poke && j == 4) start = 1'b0;
    end
    check(!bd, "R2 R3 R9 data stream", ad, ed);
    check(!bs, "R6 R7 R8 sync stream", as_, es);
    check(!bc, "R4 R5 serial clock", ac, ec);
    check(!bb, "R10 busy during frame", ab, 1);
  endtask

  task automatic rand_cfg();
    logic [127:0] tmp;
    for (int t = 0; t < NT; t++) begin
      if ($urandom_range(0, 3) == 0) link_cfg[t*LW +: LW] = 3'd7;
      else                            link_cfg[t*LW +: LW] = 3'($urandom_range(0, 6));
    end
    first_code = 3'($urandom_range(0, 6));
    div_code   = 3'($urandom_range(0, 7));
    sync_inv   = 1'($urandom_range(0, 1));
    clk_normal = 1'($urandom_range(0, 1));
    sync_early = 1'($urandom_range(0, 1));
    tag_ctl    = 2'($urandom_range(0, 3));
    tmp = {$urandom(), $urandom(), $urandom(), $urandom()};
    words = tmp[NT*W-1:0];
    tmp = {$urandom(), $urandom(), $urandom(), $urandom()};
    w_new = tmp[NT*W-1:0];
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // reset / idle state
    check(busy === 1'b0 && sdata === 1'b0 && ssync === 1'b0 && sclk === 1'b0,
          "R10 R6 R5 idle after reset {busy,sdata,ssync,sclk}",
          int'({busy, sdata, ssync, sclk}), 0);

    // R11: config latency of two edges
    sync_inv = 1'b1;
    @(negedge clk);
    check(ssync === 1'b0, "R11 sync polarity one edge after change", int'(ssync), 0);
    @(negedge clk);
    check(ssync === 1'b1, "R11 sync polarity two edges after change", int'(ssync), 1);

    // R2: self-looping in-phase chain capped at seven words, tag forced to one
    for (int t = 0; t < NT; t++) link_cfg[t*LW +: LW] = 3'd7;
    link_cfg[0 +: LW] = 3'd0;
    first_code = 3'd0; div_code = 3'b000; sync_early = 1'b1; sync_inv = 1'b0;
    clk_normal = 1'b1; tag_ctl = 2'b10; words = '0;
    words[0 +: W] = 16'hA5A4;
    run_frame(1'b0, 1'b0);

    // R4 R5: full-rate, inverted clock, late sync, tag forced to zero
    link_cfg[0 +: LW] = 3'd1; link_cfg[1*LW +: LW] = 3'd2; link_cfg[2*LW +: LW] = 3'd7;
    div_code = 3'b101; clk_normal = 1'b0; sync_early = 1'b0; tag_ctl = 2'b01;
    words[0 +: W] = 16'h1235; words[1*W +: W] = 16'hF00F; words[2*W +: W] = 16'h8001;
    run_frame(1'b0, 1'b0);

    // R1: terminator entry code does not start a frame
    first_code = 3'd7;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    check(busy === 1'b0 && sdata === 1'b0, "R1 start with entry code 111 ignored",
          int'({busy, sdata}), 0);

    // R3 + R1: inputs change after the first word is taken, stray start mid-frame
    first_code = 3'd4;
    link_cfg[4*LW +: LW] = 3'd4;
    div_code = 3'b010; sync_early = 1'b0; clk_normal = 1'b1;
    w_new = ~words;
    run_frame(1'b1, 1'b1);

    for (int k = 0; k < 30; k++) begin
      rand_cfg();
      run_frame(k % 5 == 2, k % 4 == 1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule